// File: doc/BRIEF.md
# Host–Core Mailbox Unit

This block carries 32-bit messages in both directions between a host processor and an accelerator core. The host reaches it through a small register window: it writes or reads one word at a time, selected by a two-bit address and qualified by a one-cycle write or read strobe. The core reaches it through three valid/ready streams. The core drains one stream from the host-to-core queue, and it fills two streams toward the host. Each path carries data in one direction only.

Messages from the host go into a first-in first-out queue that holds four words. Messages from the core go into two single-word holding slots. The first slot is a plain outbound mailbox. The second slot drives an interrupt line toward the host for as long as it holds a word. Both sides can see how full each path is. The host reads a status word. The core sees an entry count and the ready signals.

Back-pressure follows the usual stream rules. A transfer happens on a rising clock edge where valid and ready are both high. The core's inbound stream shows `core_in_valid` only while the queue holds data, and the core may hold `core_in_ready` high while it waits. On the two outbound streams, `ready` is high only while the slot is empty. The core must hold its word and keep `valid` high until it sees `ready`. The host side has no flow control. A host read of a register returns its value in the same cycle. A host read strobe on a full slot empties it.

Top module: `mbox_unit`

## Requirements
- R1: After reset, all three paths are empty. `irq` is low, `core_in_valid` is low, `core_in_count` is 0, both outbound ready signals are high, and the status word reads 4 free slots with no flags set.
- R2: Each host write to address 0 enqueues `host_wdata`. The core receives the words in the order they were written, one per cycle in which `core_in_valid` and `core_in_ready` are both high. `core_in_data` shows the oldest word.
- R3: While the queue is empty, `core_in_valid` stays low and a high `core_in_ready` removes nothing. The word arrives on the cycle after the host writes it.
- R4: A host write to address 0 while the queue holds 4 words and the core is not taking one replaces the newest word. The count stays at 4 and the status overflow bit (bit 16) is set. That bit stays set until the host writes any value to address 3.
- R5: `core_out_ready` is high only while the outbound mailbox is empty. A handshake loads `core_out_data`. A host read of address 1 returns the word and empties the slot on that clock edge.
- R6: The interrupt mailbox behaves the same way through `core_int_valid`, `core_int_ready` and `core_int_data`, and the host reads it at address 2. `irq` is high exactly while this slot holds a word.
- R7: The status word at address 3 holds the inbound free-slot count in bits [2:0], outbound mailbox full in bit 8, interrupt mailbox full in bit 9, and overflow in bit 16. All other bits are 0.
- R8: `core_in_count` equals the number of queued inbound words. On each outbound path, the ready signal is that path's free-slot count (0 or 1). The inbound free count plus `core_in_count` always equals 4.
- R9: The paths cannot be read or written backwards. A read of address 0 returns 0 and changes nothing. Host writes to addresses 1 and 2 change nothing. A host read of an empty slot returns 0.
- R10: A host write to address 0 on the same edge as a core take from a full queue is an ordinary enqueue. The count stays at 4, the overflow bit is not set, and no word is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (drains a full outbound slot) |
| host_addr | input | 2 | Register select: 0 inbound, 1 outbound, 2 interrupt, 3 status |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read value of the selected register, combinational |
| core_in_valid | output | 1 | Inbound queue holds a word |
| core_in_ready | input | 1 | Core takes the inbound word |
| core_in_data | output | 32 | Oldest inbound word |
| core_in_count | output | 3 | Number of queued inbound words |
| core_out_valid | input | 1 | Core offers an outbound word |
| core_out_ready | output | 1 | Outbound mailbox empty |
| core_out_data | input | 32 | Outbound word |
| core_int_valid | input | 1 | Core offers an interrupt word |
| core_int_ready | output | 1 | Interrupt mailbox empty |
| core_int_data | input | 32 | Interrupt word |
| irq | output | 1 | Interrupt toward host, high while the interrupt mailbox is full |

## Verification
The assertions check several invariants on every cycle. The queue count never exceeds its depth, and the overflow flag stays set until it is cleared. A full slot keeps its word until the host reads it. The free count and the entry count always add up to the depth. An empty queue can only become valid after a host write, and `irq` only rises after a core handshake. The bench's scenarios are needed for the rest. They cover the order in which words come out of the queue and the replacement of the newest word on overflow. They also cover the same-edge enqueue and take on a full queue, and the stalled core write that completes after a host read. Finally they cover the reads and writes in the wrong direction, which must have no effect.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int unsigned DW = 32;

  typedef enum logic [1:0] {
    ADR_INQ  = 2'd0,
    ADR_OUT  = 2'd1,
    ADR_INT  = 2'd2,
    ADR_STAT = 2'd3
  } haddr_e;

  localparam int unsigned ST_OUT_BIT = 8;
  localparam int unsigned ST_INT_BIT = 9;
  localparam int unsigned ST_OVF_BIT = 16;
endpackage

// File: rtl/mbox_inq.sv
module mbox_inq #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned DW    = 32,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  input  logic          clr_ovf,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic [CW-1:0] count,
  output logic          overflow
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] rptr, wptr, wlast;
  logic          full, do_pop, over, do_push;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full      = (count == CW'(DEPTH));
  assign out_valid = (count != '0);
  assign out_data  = mem[rptr];
  assign do_pop    = pop && out_valid;
  assign over      = push && full && !do_pop;
  assign do_push   = push && !over;
  assign wlast     = (wptr == '0) ? AW'(DEPTH - 1) : wptr - AW'(1);

  always_ff @(posedge clk) begin
    if (do_push)   mem[wptr]  <= push_data;
    else if (over) mem[wlast] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rptr     <= '0;
      wptr     <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      if (do_push) wptr <= nxt(wptr);
      if (do_pop)  rptr <= nxt(rptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
      if (over)         overflow <= 1'b1;
      else if (clr_ovf) overflow <= 1'b0;
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R2
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow && !clr_ovf |=> overflow); // R4
  AST_OVER_KEEPS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    push && full && !pop |=> full && overflow); // R4
  AST_SWAP_AT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    push && pop && full |=> full && (overflow == $past(overflow))); // R10
endmodule

// File: rtl/mbox_slot.sv
module mbox_slot #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [DW-1:0] wr_data,
  input  logic          rd,
  output logic          full,
  output logic [DW-1:0] data
);
  logic load, take;

  assign wr_ready = !full;
  assign load     = wr_valid && !full;
  assign take     = rd && full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else begin
      if (load)      full <= 1'b1;
      else if (take) full <= 1'b0;
      if (load) data <= wr_data;
    end
  end

  AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    full && !rd |=> full && $stable(data)); // R5
  AST_SLOT_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    rd && full |=> !full); // R5
endmodule

// File: rtl/mbox_unit.sv
module mbox_unit
  import mbox_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [1:0]    host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic          core_in_valid,
  input  logic          core_in_ready,
  output logic [DW-1:0] core_in_data,
  output logic [CW-1:0] core_in_count,
  input  logic          core_out_valid,
  output logic          core_out_ready,
  input  logic [DW-1:0] core_out_data,
  input  logic          core_int_valid,
  output logic          core_int_ready,
  input  logic [DW-1:0] core_int_data,
  output logic          irq
);
  logic          in_push, clr_ovf, ovf;
  logic [CW-1:0] free_cnt;
  logic [1:0]    s_wvalid, s_wready, s_rd, s_full;
  logic [DW-1:0] s_wdata [2];
  logic [DW-1:0] s_data  [2];
  logic [DW-1:0] status;

  assign in_push = host_wr && (host_addr == ADR_INQ);
  assign clr_ovf = host_wr && (host_addr == ADR_STAT);

  mbox_inq #(.DEPTH(DEPTH), .DW(DW)) u_inq (
    .clk(clk), .rst_n(rst_n),
    .push(in_push), .push_data(host_wdata),
    .pop(core_in_ready), .clr_ovf(clr_ovf),
    .out_valid(core_in_valid), .out_data(core_in_data),
    .count(core_in_count), .overflow(ovf)
  );

  assign s_wvalid   = {core_int_valid, core_out_valid};
  assign s_wdata[0] = core_out_data;
  assign s_wdata[1] = core_int_data;
  assign s_rd[0]    = host_rd && (host_addr == ADR_OUT);
  assign s_rd[1]    = host_rd && (host_addr == ADR_INT);

  for (genvar g = 0; g < 2; g++) begin : g_slot
    mbox_slot #(.DW(DW)) u_slot (
      .clk(clk), .rst_n(rst_n),
      .wr_valid(s_wvalid[g]), .wr_ready(s_wready[g]), .wr_data(s_wdata[g]),
      .rd(s_rd[g]), .full(s_full[g]), .data(s_data[g])
    );
  end

  assign core_out_ready = s_wready[0];
  assign core_int_ready = s_wready[1];
  assign irq            = s_full[1];
  assign free_cnt       = CW'(DEPTH) - core_in_count;

  always_comb begin
    status             = '0;
    status[CW-1:0]     = free_cnt;
    status[ST_OUT_BIT] = s_full[0];
    status[ST_INT_BIT] = s_full[1];
    status[ST_OVF_BIT] = ovf;
  end

  always_comb begin
    case (host_addr)
      ADR_OUT:  host_rdata = s_full[0] ? s_data[0] : '0;
      ADR_INT:  host_rdata = s_full[1] ? s_data[1] : '0;
      ADR_STAT: host_rdata = status;
      default:  host_rdata = '0;
    endcase
  end

  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(core_int_valid)); // R6
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !core_in_valid && !in_push |=> !core_in_valid); // R3
  AST_COUNT_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    (status[CW-1:0] + core_in_count) == CW'(DEPTH)); // R8
endmodule

// File: tb/mbox_unit_bench.sv
`timescale 1ns/1ps
module mbox_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 0, host_rd = 0;
  logic [1:0]  host_addr = 0;
  logic [31:0] host_wdata = 0, host_rdata;
  logic        core_in_valid, core_in_ready = 0;
  logic [31:0] core_in_data;
  logic [2:0]  core_in_count;
  logic        core_out_valid = 0, core_out_ready;
  logic [31:0] core_out_data = 0;
  logic        core_int_valid = 0, core_int_ready;
  logic [31:0] core_int_data = 0;
  logic        irq;

  int errors = 0, checks = 0;

  // behavioural reference state
  int unsigned q[$];
  bit          m_of, m_if, m_ovf;
  int unsigned m_od, m_id;

  always #2.5 clk = ~clk;

  mbox_unit u_mbox_unit (.*);

  task automatic chk(input string tag, input int unsigned act, input int unsigned exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int unsigned m_status();
    return (4 - q.size()) | (int'(m_of) << 8) | (int'(m_if) << 9) | (int'(m_ovf) << 16);
  endfunction

  function automatic int unsigned m_rdata();
    case (host_addr)
      2'd1: return m_of ? m_od : 0;
      2'd2: return m_if ? m_id : 0;
      2'd3: return m_status();
      default: return 0;
    endcase
  endfunction

  task automatic compare();
    chk("R2 in_valid", core_in_valid, q.size() != 0);
    if (q.size() != 0) chk("R2 in_data", core_in_data, q[0]);
    chk("R8 in_count", core_in_count, q.size());
    chk("R5 out_ready", core_out_ready, !m_of);
    chk("R6 int_ready", core_int_ready, !m_if);
    chk("R6 irq", irq, m_if);
    chk("R7 rdata", host_rdata, m_rdata());
  endtask

  task automatic model_step();
    bit pop, ld_o, ld_i;
    pop  = core_in_ready && q.size() != 0;
    ld_o = core_out_valid && !m_of;
    ld_i = core_int_valid && !m_if;
    if (pop) void'(q.pop_front());
    if (host_wr && host_addr == 2'd0) begin
      if (q.size() == 4) begin q[3] = host_wdata; m_ovf = 1; end
      else q.push_back(host_wdata);
    end else if (host_wr && host_addr == 2'd3) m_ovf = 0;
    if (host_rd && host_addr == 2'd1 && m_of) m_of = 0;
    if (host_rd && host_addr == 2'd2 && m_if) m_if = 0;
    if (ld_o) begin m_of = 1; m_od = core_out_data; end
    if (ld_i) begin m_if = 1; m_id = core_int_data; end
  endtask

  // apply current inputs for one cycle: compare, clock, update model, idle strobes
  task automatic tick();
    #1 compare();
    @(posedge clk);
    model_step();
    @(negedge clk);
    host_wr = 0; host_rd = 0; core_in_ready = 0;
    core_out_valid = 0; core_int_valid = 0;
  endtask

  task automatic hwrite(input logic [1:0] a, input int unsigned d);
    host_wr = 1; host_addr = a; host_wdata = d; tick();
  endtask

  task automatic hread(input logic [1:0] a);
    host_rd = 1; host_addr = a; tick();
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    host_addr = 2'd3; #1;
    chk("R1 status", host_rdata, 32'h4);
    chk("R1 irq", irq, 0);
    chk("R1 in_valid", core_in_valid, 0);
    chk("R1 ready", {core_out_ready, core_int_ready}, 2'b11);
    @(negedge clk);

    // R3 stall: ready with empty queue removes nothing
    core_in_ready = 1; tick();
    core_in_ready = 1; tick();
    hwrite(2'd0, 32'hA1);
    #1 chk("R3 arrives", core_in_data, 32'hA1);
    @(negedge clk);
    core_in_ready = 1; tick();

    // R2 order
    hwrite(2'd0, 32'h11); hwrite(2'd0, 32'h22); hwrite(2'd0, 32'h33);
    #1 chk("R2 head", core_in_data, 32'h11);
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin core_in_ready = 1; tick(); end

    // R4 overflow replaces newest
    for (int i = 1; i <= 5; i++) hwrite(2'd0, 32'h100 + i);
    host_addr = 2'd3; #1 chk("R4 ovf bit", host_rdata, 32'h10000);
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin core_in_ready = 1; tick(); end
    #1 chk("R4 newest replaced", core_in_data, 32'h105);
    @(negedge clk);
    core_in_ready = 1; tick();
    hwrite(2'd3, 0);
    host_addr = 2'd3; #1 chk("R4 cleared", host_rdata, 32'h4);
    @(negedge clk);

    // R10 push and take at full
    for (int i = 0; i < 4; i++) hwrite(2'd0, 32'h200 + i);
    host_wr = 1; host_addr = 0; host_wdata = 32'h2FF; core_in_ready = 1; tick();
    host_addr = 2'd3; #1 chk("R10 no ovf", host_rdata, 32'h0);
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin core_in_ready = 1; tick(); end

    // R5 outbound, stalled second write
    core_out_valid = 1; core_out_data = 32'hC0DE; tick();
    core_out_valid = 1; core_out_data = 32'hBEEF; tick();
    host_addr = 2'd1; #1 chk("R5 held", host_rdata, 32'hC0DE);
    @(negedge clk);
    hread(2'd1);
    core_out_valid = 1; core_out_data = 32'hBEEF; tick();
    hread(2'd1);

    // R6 interrupt mailbox
    core_int_valid = 1; core_int_data = 32'h1234; tick();
    #1 chk("R6 irq high", irq, 1);
    @(negedge clk);
    hread(2'd2);
    #1 chk("R6 irq low", irq, 0);
    @(negedge clk);

    // R9 wrong directions
    hwrite(2'd0, 32'h77);
    hread(2'd0);
    #1 chk("R9 inq kept", core_in_count, 1);
    @(negedge clk);
    hwrite(2'd1, 32'h55); hwrite(2'd2, 32'h66);
    #1 chk("R9 slots empty", {core_out_ready, core_int_ready}, 2'b11);
    @(negedge clk);
    hread(2'd1);
    core_in_ready = 1; tick();
    tick();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule